// File: doc/BRIEF.md
# Protected Control Register Unit

The unit holds an 8-bit control register for a serial memory with supervisor functions. The register carries a two-bit watchdog period, a three-bit block-protect code and two volatile write-enable latches. A bus front end hands the unit the data bytes of each write transaction. Each byte arrives with a one-cycle valid strobe, and a separate strobe marks the end of the transaction. A select level tells the unit whether the transaction targets the control register or the memory array. For array writes the front end also supplies the byte's array address. A write-protect pin level is sampled alongside the bytes.

For every accepted byte the unit returns an acknowledge decision one cycle later. Register writes take effect only when the transaction ends. The watchdog and protect fields change only after a three-step unlock: first the write latch, then the register latch, then the value. Storing those fields starts a busy interval. During that interval the unit refuses every byte. The nonvolatile cells are modelled as flops plus a cycle counter. A combinational permit output tells the array whether a write to the presented address is allowed right now.

Top module: `prot_ctrl_reg`

## Requirements
- R1: While reset is asserted the register reads 00h, busy is low and no acknowledge pulse is given.
- R2: The register reads {0, WD[1:0], BP[1:0], RWEL, WEL, BP[2]} from bit 7 down to bit 0, so bit 7 is always 0.
- R3: With RWEL clear, a register byte other than 06h-with-WEL-set copies its bit 1 into WEL when the transaction ends, so 02h sets WEL. This causes no busy interval. While WEL is clear, a register byte whose bit 1 is 0 gets no acknowledge and changes nothing.
- R4: With WEL set and RWEL clear, the byte 06h sets RWEL and keeps WEL when the transaction ends, with no busy interval.
- R5: With RWEL and WEL set, a byte whose bit 2 is 0 does four things when the transaction ends. It loads WD from bits 6:5 and BP from bits 0,4,3. It copies bit 1 into WEL and clears RWEL. It raises busy for BUSY_CYCLES cycles, starting in the cycle after the ending edge. The sequence 02h, 06h, 02h therefore zeroes the stored fields.
- R6: With RWEL and WEL set, a byte whose bit 2 is 1 is acknowledged but changes nothing, so 02h, 06h, 06h leaves the stored fields alone and RWEL set.
- R7: A byte sampled while busy is high gets no acknowledge and changes nothing. The first byte after busy falls is handled normally.
- R8: A byte sampled with the write-protect pin high gets no acknowledge and changes nothing.
- R9: A second register byte in one transaction gets no acknowledge and cancels the pending write, so the transaction's end changes nothing.
- R10: An array byte is acknowledged only if WEL is set, the pin is low, busy is low and the address is not protected. The permit output shows the same condition for the presented address in the same cycle.
- R11: BP protects these addresses: 000 none; 001 180h-1FFh; 010 100h-1FFh; 011 all; 100 000h-00Fh; 101 000h-01Fh; 110 000h-03Fh; 111 000h-07Fh.
- R12: An array byte to a protected address sampled while busy is low clears RWEL in the next cycle.
- R13: The acknowledge pulse (ackValid with ackOk) appears in the cycle after the byte's valid cycle. A byte whose valid coincides with the end strobe is dropped and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrByte | input | 8 | Data byte from the bus front end |
| wrValid | input | 1 | One-cycle strobe: wrByte holds a data byte |
| wrEnd | input | 1 | One-cycle strobe: the write transaction has ended |
| targetReg | input | 1 | 1 = transaction addresses the control register, 0 = the array |
| arrAddr | input | ADDR_W | Array address of the current byte |
| wpPin | input | 1 | Write-protect pin level, high blocks all writes |
| ctrlReg | output | 8 | Control register contents |
| ackValid | output | 1 | Acknowledge decision present |
| ackOk | output | 1 | 1 = byte acknowledged, 0 = refused |
| busy | output | 1 | Nonvolatile store in progress |
| permit | output | 1 | Write to arrAddr would be accepted now |

## Verification
Two functions can meet in one cycle: the busy counter running out, and a new byte being judged against busy. The bench provokes this by committing a stored value and then streaming array bytes every cycle across the whole busy window. A per-cycle reference model decides, edge by edge, which byte is the first one acknowledged. A second meeting is a byte valid on the same edge as the end strobe. The model expects that byte to be dropped and the pending register write to commit unchanged.

// File: rtl/prot_ctrl_pkg.sv
package prot_ctrl_pkg;

  // Strobes from control to datapath, all single-cycle.
  typedef struct packed {
    logic       loadWel;
    logic       welVal;
    logic       setRwel;
    logic       clrRwel;
    logic       loadNv;
    logic [1:0] wdVal;
    logic [2:0] bpVal;
  } regStrobe_t;

  localparam logic [7:0] REG_UNLOCK_BYTE = 8'h06;

endpackage

// File: rtl/prot_busy_timer.sv
module prot_busy_timer #(
  parameter int BUSY_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic startBusy,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (startBusy)      cnt <= CNT_LOAD;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R5: a store raises busy on the next cycle
  p_busy_follows_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    startBusy |=> busy);

endmodule

// File: rtl/prot_ctrl_dp.sv
module prot_ctrl_dp
  import prot_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        ctrlReg,
  output logic              welQ,
  output logic              rwelQ,
  output logic              protHit
);
  localparam int LOW_GROUPS = 4;

  logic [1:0] wdQ;
  logic [2:0] bpQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdQ   <= '0;
      bpQ   <= '0;
      welQ  <= 1'b0;
      rwelQ <= 1'b0;
    end else begin
      if (strobe.loadNv) begin
        wdQ <= strobe.wdVal;
        bpQ <= strobe.bpVal;
      end
      if (strobe.loadWel) welQ <= strobe.welVal;
      if (strobe.setRwel)      rwelQ <= 1'b1;
      else if (strobe.clrRwel) rwelQ <= 1'b0;
    end
  end

  assign ctrlReg = {1'b0, wdQ, bpQ[1:0], rwelQ, welQ, bpQ[2]};

  // Low-page groups: 1, 2, 4 and 8 pages from address zero.
  logic [LOW_GROUPS-1:0] lowHit;
  for (genvar k = 0; k < LOW_GROUPS; k++) begin : g_low
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(PAGE_BYTES << k);
    assign lowHit[k] = ({1'b0, arrAddr} < LIMIT);
  end

  logic upperQuarter, upperHalf;
  assign upperQuarter = (arrAddr[ADDR_W-1 -: 2] == 2'b11);
  assign upperHalf    = arrAddr[ADDR_W-1];

  always_comb begin
    unique case (bpQ)
      3'b000:  protHit = 1'b0;
      3'b001:  protHit = upperQuarter;
      3'b010:  protHit = upperHalf;
      3'b011:  protHit = 1'b1;
      default: protHit = lowHit[bpQ[1:0]];
    endcase
  end

  // R4: RWEL can only exist with WEL set
  p_rwel_implies_wel_r4: assert property (@(posedge clk) disable iff (!rstN)
    rwelQ |-> welQ);

  // R5: stored fields change only out of the fully unlocked state
  p_nv_needs_unlock_r5: assert property (@(posedge clk) disable iff (!rstN)
    ({wdQ, bpQ} != $past({wdQ, bpQ})) |-> $past(rwelQ && welQ));

endmodule

// File: rtl/prot_ctrl_fsm.sv
module prot_ctrl_fsm
  import prot_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] wrByte,
  input  logic       wrValid,
  input  logic       wrEnd,
  input  logic       targetReg,
  input  logic       wpPin,
  input  logic       busy,
  input  logic       welQ,
  input  logic       rwelQ,
  input  logic       protHit,
  output logic       ackValid,
  output logic       ackOk,
  output logic       permit,
  output logic       startBusy,
  output regStrobe_t strobe
);
  logic       accept, blocked, regOk, arrOk, byteOk, commit;
  logic       regSeen, pendValid;
  logic [7:0] pendByte;

  assign accept  = wrValid & ~wrEnd;
  assign blocked = busy | wpPin;
  assign regOk   = ~blocked & ~regSeen & (welQ | wrByte[1]);
  assign arrOk   = ~blocked & welQ & ~protHit;
  assign byteOk  = targetReg ? regOk : arrOk;
  assign permit  = welQ & ~wpPin & ~busy & ~protHit;
  assign commit  = wrEnd & pendValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid  <= 1'b0;
      ackOk     <= 1'b0;
      regSeen   <= 1'b0;
      pendValid <= 1'b0;
      pendByte  <= '0;
    end else begin
      ackValid <= accept;
      ackOk    <= accept & byteOk;
      if (wrEnd) begin
        regSeen   <= 1'b0;
        pendValid <= 1'b0;
      end else if (accept && targetReg) begin
        regSeen   <= 1'b1;
        pendValid <= regOk;
        pendByte  <= wrByte;
      end
    end
  end

  always_comb begin
    strobe    = '0;
    startBusy = 1'b0;
    if (commit) begin
      if (rwelQ && welQ) begin
        if (!pendByte[2]) begin
          strobe.loadNv  = 1'b1;
          strobe.wdVal   = pendByte[6:5];
          strobe.bpVal   = {pendByte[0], pendByte[4:3]};
          strobe.clrRwel = 1'b1;
          strobe.loadWel = 1'b1;
          strobe.welVal  = pendByte[1];
          startBusy      = 1'b1;
        end
      end else if (welQ && pendByte == REG_UNLOCK_BYTE) begin
        strobe.setRwel = 1'b1;
        strobe.loadWel = 1'b1;
        strobe.welVal  = 1'b1;
      end else begin
        strobe.loadWel = 1'b1;
        strobe.welVal  = pendByte[1];
      end
    end else if (accept && !targetReg && !busy && protHit) begin
      strobe.clrRwel = 1'b1;
    end
  end

  // R8: the pin refuses every byte
  p_wp_refuses_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && wpPin) |=> (ackValid && !ackOk));

  // R7: bytes during busy are refused
  p_busy_refuses_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accept && busy) |=> !ackOk);

  // R9: second register byte refused
  p_second_byte_r9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && targetReg && regSeen) |=> !ackOk);

  // R12: protected array byte drops RWEL
  p_prot_clears_rwel_r12: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !targetReg && !busy && protHit) |=> !rwelQ);

  // R13: byte coinciding with end strobe yields no pulse
  p_end_drops_byte_r13: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrEnd) |=> !ackValid);

endmodule

// File: rtl/prot_ctrl_reg.sv
module prot_ctrl_reg
  import prot_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        wrByte,
  input  logic              wrValid,
  input  logic              wrEnd,
  input  logic              targetReg,
  input  logic [ADDR_W-1:0] arrAddr,
  input  logic              wpPin,
  output logic [7:0]        ctrlReg,
  output logic              ackValid,
  output logic              ackOk,
  output logic              busy,
  output logic              permit
);
  regStrobe_t strobe;
  logic welQ, rwelQ, protHit, startBusy;

  prot_ctrl_fsm u_fsm (
    .clk, .rstN, .wrByte, .wrValid, .wrEnd, .targetReg, .wpPin, .busy,
    .welQ, .rwelQ, .protHit, .ackValid, .ackOk, .permit, .startBusy, .strobe
  );

  prot_ctrl_dp #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk, .rstN, .strobe, .arrAddr, .ctrlReg, .welQ, .rwelQ, .protHit
  );

  prot_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk, .rstN, .startBusy, .busy
  );

endmodule

// File: tb/tb_prot_ctrl_reg.sv
module tb_prot_ctrl_reg;
  localparam int BUSY = 20;

  logic       clk = 1'b0, rstN = 1'b0;
  logic [7:0] wrByte = '0;
  logic       wrValid = 1'b0, wrEnd = 1'b0, targetReg = 1'b0, wpPin = 1'b0;
  logic [8:0] arrAddr = '0;
  logic [7:0] ctrlReg;
  logic       ackValid, ackOk, busy, permit;

  always #4 clk = ~clk;

  prot_ctrl_reg #(.ADDR_W(9), .PAGE_BYTES(16), .BUSY_CYCLES(BUSY)) dut (
    .clk, .rstN, .wrByte, .wrValid, .wrEnd, .targetReg, .arrAddr, .wpPin,
    .ctrlReg, .ackValid, .ackOk, .busy, .permit
  );

  int checks = 0, fails = 0, cycles = 0;
  logic lastAck;

  // Reference model state
  logic [1:0] mWd;
  logic [2:0] mBp;
  logic       mWel, mRwel, mSeen, mPend, mAckV, mAckOk;
  logic [7:0] mPendByte;
  int         mBusy;

  function automatic logic isProt(int a, logic [2:0] bp);
    case (bp)
      3'd0: return 1'b0;
      3'd1: return a >= 384;
      3'd2: return a >= 256;
      3'd3: return 1'b1;
      3'd4: return a < 16;
      3'd5: return a < 32;
      3'd6: return a < 64;
      default: return a < 128;
    endcase
  endfunction

  function automatic logic [7:0] expReg();
    return {1'b0, mWd, mBp[1:0], mRwel, mWel, mBp[2]};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mWd = 0; mBp = 0; mWel = 0; mRwel = 0; mSeen = 0; mPend = 0;
      mAckV = 0; mAckOk = 0; mPendByte = 0; mBusy = 0;
    end else begin
      logic oW, oR, oB, acc, ok;
      oW = mWel; oR = mRwel; oB = (mBusy > 0);
      acc = wrValid && !wrEnd;
      mAckV = acc; mAckOk = 0;
      if (acc) begin
        if (targetReg) begin
          ok = !oB && !wpPin && !mSeen && (oW || wrByte[1]);
          mSeen = 1; mPend = ok; mPendByte = wrByte; mAckOk = ok;
        end else begin
          ok = !oB && !wpPin && oW && !isProt(int'(arrAddr), mBp);
          mAckOk = ok;
          if (!oB && isProt(int'(arrAddr), mBp)) mRwel = 0;
        end
      end
      if (mBusy > 0) mBusy--;
      if (wrEnd) begin
        if (mPend) begin
          if (oR && oW) begin
            if (!mPendByte[2]) begin
              mWd = mPendByte[6:5]; mBp = {mPendByte[0], mPendByte[4:3]};
              mRwel = 0; mWel = mPendByte[1]; mBusy = BUSY;
            end
          end else if (oW && mPendByte == 8'h06) begin
            mRwel = 1; mWel = 1;
          end else mWel = mPendByte[1];
        end
        mSeen = 0; mPend = 0;
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) if (rstN) begin
    chk("R2 ctrlReg", ctrlReg, expReg());
    chk("R7 busy", busy, (mBusy > 0));
    chk("R13 ackValid", ackValid, mAckV);
    chk("R10 ackOk", ackOk, mAckOk);
    chk("R11 permit", permit,
        mWel && !wpPin && !(mBusy > 0) && !isProt(int'(arrAddr), mBp));
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  task automatic cyc(); @(negedge clk); #1; endtask

  task automatic sendByte(logic [7:0] b, logic tgt, logic [8:0] a);
    wrByte = b; targetReg = tgt; arrAddr = a; wrValid = 1; wrEnd = 0;
    cyc();
    lastAck = ackOk;
    wrValid = 0;
    cyc();
  endtask

  task automatic endTxn(); wrEnd = 1; cyc(); wrEnd = 0; cyc(); endtask

  task automatic regWrite(logic [7:0] b); sendByte(b, 1, 0); endTxn(); endtask

  task automatic waitIdle(); while (busy) cyc(); cyc(); endtask

  initial begin
    #20;
    chk("R1 reset ctrlReg", ctrlReg, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset ackValid", ackValid, 0);
    @(negedge clk); rstN = 1; cyc();

    sendByte(8'h55, 0, 9'h040);
    chk("R10 array byte with WEL clear", lastAck, 0);
    regWrite(8'h00);
    chk("R3 00h with WEL clear nacked", lastAck, 0);
    chk("R3 00h no change", ctrlReg, 8'h00);
    regWrite(8'h02);
    chk("R3 02h acked", lastAck, 1);
    chk("R3 02h sets WEL", ctrlReg, 8'h02);
    chk("R3 no busy", busy, 0);
    sendByte(8'hA5, 0, 9'h1FF);
    chk("R10 array byte acked", lastAck, 1);

    regWrite(8'h06);
    chk("R4 06h sets RWEL", ctrlReg, 8'h06);
    chk("R4 no busy", busy, 0);
    regWrite(8'h06);
    chk("R6 06h when unlocked acked", lastAck, 1);
    chk("R6 no change", ctrlReg, 8'h06);
    regWrite(8'h4B);
    chk("R5 stored value", ctrlReg, 8'h4B);
    chk("R2 bit7 zero", ctrlReg[7], 0);
    chk("R5 busy raised", busy, 1);
    regWrite(8'h02);
    chk("R7 byte during busy nacked", lastAck, 0);
    waitIdle();
    arrAddr = 9'h01F; cyc();
    chk("R11 code 101 protects 01Fh", permit, 0);
    arrAddr = 9'h020; cyc();
    chk("R11 code 101 frees 020h", permit, 1);

    for (int c = 0; c < 8; c++) begin
      logic [2:0] bp = 3'(c);
      regWrite(8'h02); regWrite(8'h06);
      regWrite({3'b000, bp[1:0], 1'b0, 1'b1, bp[2]});
      waitIdle();
      for (int a = 0; a < 512; a += 15) begin
        arrAddr = 9'(a); cyc();
        chk("R11 protect map", permit, !isProt(a, bp));
      end
    end

    regWrite(8'h02); regWrite(8'h06); regWrite(8'h02);
    chk("R5 02h,06h,02h zeroes fields", ctrlReg, 8'h02);
    waitIdle();
    regWrite(8'h02); regWrite(8'h06); regWrite(8'h06);
    chk("R6 02h,06h,06h keeps RWEL", ctrlReg, 8'h06);

    regWrite(8'h0A); waitIdle();
    regWrite(8'h06);
    chk("R4 RWEL set again", ctrlReg, 8'h0E);
    sendByte(8'h11, 0, 9'h180);
    chk("R12 protected byte nacked", lastAck, 0);
    chk("R12 RWEL cleared", ctrlReg, 8'h0A);

    wpPin = 1;
    regWrite(8'h06);
    chk("R8 register byte nacked", lastAck, 0);
    chk("R8 register unchanged", ctrlReg, 8'h0A);
    sendByte(8'h33, 0, 9'h000);
    chk("R8 array byte nacked", lastAck, 0);
    wpPin = 0; cyc();

    sendByte(8'h06, 1, 0);
    chk("R9 first byte acked", lastAck, 1);
    sendByte(8'h06, 1, 0);
    chk("R9 second byte nacked", lastAck, 0);
    endTxn();
    chk("R9 pending cancelled", ctrlReg, 8'h0A);

    wrByte = 8'h00; targetReg = 1; wrValid = 1; wrEnd = 1; cyc();
    chk("R13 no pulse for byte on end", ackValid, 0);
    wrValid = 0; wrEnd = 0; cyc();
    chk("R13 dropped byte no effect", ctrlReg, 8'h0A);

    // Stream array bytes across the busy window and its end
    regWrite(8'h06); regWrite(8'h02);
    targetReg = 0; arrAddr = 9'h100; wrByte = 8'h77; wrValid = 1;
    for (int i = 0; i < BUSY + 4; i++) cyc();
    chk("R7 bytes after busy acked", ackOk, 1);
    wrValid = 0; cyc(); cyc();

    summary();
  end
endmodule